// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the transmit side of a clocked synchronous serial channel. Bytes written by the CPU are sent eight bits at a time, least significant bit first, on a serial data line. The block can run as clock master, where it makes the serial clock by dividing the system clock. It can also run as clock slave, where an external serial clock is synchronised and its edges move the data.

Between the CPU and the shift register there can be a holding register. An optional four-entry FIFO can sit in front of that. The block moves data forward through these stages at frame boundaries and raises a one-cycle transmit interrupt. It reports whether the holding register is free, and keeps two sticky error flags: one for a write that was dropped, and one for a slave-mode frame clock that arrived with nothing to send. A status-read strobe clears both flags.

Top module: `sync_ser_tx`

## Requirements
- R1: After reset the holding-empty flag is 1, underrun, overflow and tx_irq are 0, and both sdo and sclk_out are high.
- R2: A frame is 8 bits sent LSB first. In master mode sclk_out idles high, each half period lasts SCLK_HALF system clocks, sdo changes on sclk_out falling edges, and sdo is valid at each of the 8 rising edges.
- R3: With dbuf_en=0 a write goes straight into the shift register. tx_irq gives one one-cycle pulse when that frame completes, and no pulse when the byte is loaded.
- R4: With dbuf_en=1 and fifo_en=0 a write fills the holding register and drives hold_empty to 0. Moving the byte into the shift register sets hold_empty to 1 and pulses tx_irq. A byte waiting in the holding register is sent right after the current frame.
- R5: In master mode sclk_out stops high once a frame finishes and no byte is waiting.
- R6: In slave mode (clk_master=0) bits are moved by sclk_in edges through a two-flop synchroniser, and sclk_out stays high.
- R7: With fifo_en=1 and dbuf_en=1, writes enter a 4-entry FIFO and an empty holding register is reloaded from it on the next cycle. At the end of a frame the holding byte moves to the shifter and the FIFO head moves to the holding register in the same cycle.
- R8: A write that finds its target stage full (a full FIFO, a full holding register, or a busy shifter in single-buffer mode) is dropped and sets overflow. Overflow stays set until a stat_rd pulse.
- R9: In slave mode with the FIFO off, once a frame completes with no refill, the first falling sclk_in edge seen while both stages are empty sets underrun. Underrun is never set in master mode. A stat_rd pulse clears it.
- R10: In slave mode, a byte written before the next frame clock arrives is sent in that frame and no underrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | WIDTH | CPU write data |
| dbuf_en | input | 1 | Enables the holding register |
| fifo_en | input | 1 | Enables the FIFO (only when dbuf_en=1) |
| clk_master | input | 1 | 1: block generates the serial clock; 0: clocked by sclk_in |
| sclk_in | input | 1 | External serial clock (slave mode) |
| stat_rd | input | 1 | Status read strobe, clears underrun and overflow |
| sdo | output | 1 | Serial data out, high when idle |
| sclk_out | output | 1 | Generated serial clock, high when idle |
| tx_irq | output | 1 | One-cycle transmit interrupt |
| hold_empty | output | 1 | Holding register is empty |
| underrun | output | 1 | Sticky slave-mode underrun flag |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
Single-buffer, double-buffer and FIFO traffic are each sent in master mode. Comparing the tx_irq timing across these separates an interrupt raised when the frame completes from one raised when the holding register hands over its byte. A burst of seven writes into the FIFO shows that exactly six bytes fit across FIFO, holding register and shifter. In slave mode the bench drives frames with nothing queued, with a byte queued ahead of time, and with a filled FIFO. These three cases separate a true underrun from a refill that arrived in time, and show that the two-stage transfer keeps the holding register occupied.

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int WIDTH      = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int SCLK_HALF  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             dbuf_en,
  input  logic             fifo_en,
  input  logic             clk_master,
  input  logic             sclk_in,
  input  logic             stat_rd,
  output logic             sdo,
  output logic             sclk_out,
  output logic             tx_irq,
  output logic             hold_empty,
  output logic             underrun,
  output logic             overflow
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int NW = $clog2(FIFO_DEPTH + 1);
  localparam int DW = $clog2(SCLK_HALF + 1);

  logic [WIDTH-1:0] sh, hold;
  logic             sh_full, hold_full, armed, sclk_r;
  logic [CW-1:0]    bcnt;
  logic [DW-1:0]    dcnt;
  logic [NW-1:0]    fifo_cnt;
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [WIDTH-1:0] mem [FIFO_DEPTH];
  logic             s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {sclk_in, s1, s2};

  wire tick    = clk_master && sh_full && (dcnt == DW'(SCLK_HALF - 1));
  wire rise_ev = tick ? !sclk_r : (!clk_master && s2 && !s3);
  wire fall_ev = tick ?  sclk_r : (!clk_master && !s2 && s3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       begin dcnt <= '0; sclk_r <= 1'b1; end
    else if (!(clk_master && sh_full)) begin dcnt <= '0; sclk_r <= 1'b1; end
    else if (tick)                    begin dcnt <= '0; sclk_r <= !sclk_r; end
    else                              dcnt <= dcnt + 1'b1;

  wire fen        = fifo_en && dbuf_en;
  wire frame_done = sh_full && rise_ev && (bcnt == CW'(WIDTH - 1));
  wire move       = dbuf_en && hold_full && (!sh_full || frame_done);
  wire fifo_nz    = fifo_cnt != '0;
  wire fifo_full  = fifo_cnt == NW'(FIFO_DEPTH);
  wire pop        = fen && fifo_nz && (!hold_full || move);
  wire push       = fen && wr_en && !fifo_full;
  wire wr_hold    = dbuf_en && !fen && wr_en && !hold_full;
  wire wr_sh      = !dbuf_en && wr_en && !sh_full;
  wire drop       = wr_en && !(push || wr_hold || wr_sh);
  wire ur_set     = armed && fall_ev && !clk_master && !fen && !sh_full && !hold_full;

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_ptr <= '0; wr_ptr <= '0; fifo_cnt <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(FIFO_DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(FIFO_DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      fifo_cnt <= fifo_cnt + 1'b1;
      else if (pop && !push) fifo_cnt <= fifo_cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh <= '0; sh_full <= 1'b0; bcnt <= '0;
    end else if (move) begin
      sh <= hold; sh_full <= 1'b1; bcnt <= '0;
    end else if (frame_done) begin
      sh_full <= 1'b0;
    end else if (wr_sh) begin
      sh <= wr_data; sh_full <= 1'b1; bcnt <= '0;
    end else if (sh_full) begin
      if (rise_ev) bcnt <= bcnt + 1'b1;
      if (fall_ev && bcnt != '0) sh <= sh >> 1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold <= '0; hold_full <= 1'b0;
    end else if (move || (!hold_full && pop)) begin
      hold <= mem[rd_ptr]; hold_full <= pop;
    end else if (wr_hold) begin
      hold <= wr_data; hold_full <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_irq <= 1'b0; armed <= 1'b0; underrun <= 1'b0; overflow <= 1'b0;
    end else begin
      tx_irq <= dbuf_en ? move : frame_done;
      if (move || wr_sh || ur_set)                  armed <= 1'b0;
      else if (frame_done && !clk_master && !fen)   armed <= 1'b1;
      if (ur_set)       underrun <= 1'b1;
      else if (stat_rd) underrun <= 1'b0;
      if (drop)         overflow <= 1'b1;
      else if (stat_rd) overflow <= 1'b0;
    end

  assign sdo        = sh_full ? sh[0] : 1'b1;
  assign sclk_out   = sclk_r;
  assign hold_empty = !hold_full;

  // R3
  irq_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en && frame_done |=> tx_irq);
  // R4
  hold_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbuf_en && !fen && move |=> hold_empty && tx_irq);
  // R5
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_full |-> sclk_out);
  // R7
  fifo_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_empty && fen && fifo_nz |=> !hold_empty);
  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !stat_rd |=> overflow);
  // R9
  master_no_ur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_master && !underrun |=> !underrun);
endmodule

// File: tb/tb_sync_ser_tx.sv
module tb_sync_ser_tx;
  localparam int HALF = 4;
  localparam int FRAME = 16 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, dbuf_en = 1'b0, fifo_en = 1'b0, clk_master = 1'b1;
  logic sclk_in = 1'b1, stat_rd = 1'b0;
  logic [7:0] wr_data = '0;
  logic sdo, sclk_out, tx_irq, hold_empty, underrun, overflow;

  int nchk = 0, nfail = 0;
  int rx_n = 0, rise_cnt = 0, irq_cnt = 0, nb = 0;
  logic [7:0] rxq [64];
  logic [7:0] acc = '0;
  logic p_sclk = 1'b1, p_sdo = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_ser_tx #(.WIDTH(8), .FIFO_DEPTH(4), .SCLK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .dbuf_en(dbuf_en), .fifo_en(fifo_en), .clk_master(clk_master),
    .sclk_in(sclk_in), .stat_rd(stat_rd), .sdo(sdo), .sclk_out(sclk_out),
    .tx_irq(tx_irq), .hold_empty(hold_empty), .underrun(underrun),
    .overflow(overflow));

  always @(negedge clk) begin
    if (sclk_out && !p_sclk) begin
      acc = {p_sdo, acc[7:1]};
      nb++;
      rise_cnt++;
      if (nb == 8) begin
        rxq[rx_n % 64] = acc;
        rx_n++;
        nb = 0;
      end
    end
    p_sclk = sclk_out;
    p_sdo  = sdo;
    if (tx_irq) irq_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic sframe(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk_in = 1'b0;
      repeat (6) @(negedge clk);
      b[i] = sdo;
      sclk_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    chk("R6 sclk_out high in slave mode", sclk_out, 1);
  endtask

  task automatic t_reset();
    chk("R1 hold_empty", hold_empty, 1);
    chk("R1 underrun", underrun, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 tx_irq", tx_irq, 0);
    chk("R1 sdo idle", sdo, 1);
    chk("R1 sclk_out idle", sclk_out, 1);
  endtask

  task automatic t_single();
    int b0, i0, r0;
    dbuf_en = 1'b0; fifo_en = 1'b0; clk_master = 1'b1;
    b0 = rx_n; i0 = irq_cnt; r0 = rise_cnt;
    wr(8'hA5);
    repeat (4) @(negedge clk);
    chk("R3 no irq at load", irq_cnt - i0, 0);
    repeat (FRAME + 10) @(negedge clk);
    chk("R3 one irq at frame end", irq_cnt - i0, 1);
    chk("R2 byte LSB first", rxq[b0 % 64], 8'hA5);
    chk("R2 eight rising edges", rise_cnt - r0, 8);
  endtask

  task automatic t_double();
    int b0, i0, r0;
    dbuf_en = 1'b1; fifo_en = 1'b0; clk_master = 1'b1;
    b0 = rx_n; i0 = irq_cnt; r0 = rise_cnt;
    wr(8'h3C);
    repeat (2) @(negedge clk);
    chk("R4 hold empty after move", hold_empty, 1);
    chk("R4 irq on move", irq_cnt - i0, 1);
    wr(8'hC3);
    chk("R4 hold full while shifter busy", hold_empty, 0);
    repeat (2 * FRAME + 20) @(negedge clk);
    chk("R4 first byte", rxq[b0 % 64], 8'h3C);
    chk("R4 second byte", rxq[(b0 + 1) % 64], 8'hC3);
    chk("R4 two irqs", irq_cnt - i0, 2);
    chk("R5 sixteen rising edges", rise_cnt - r0, 16);
    chk("R5 sclk stopped high", sclk_out, 1);
    repeat (50) @(negedge clk);
    chk("R5 no further edges", rise_cnt - r0, 16);
    chk("R9 no underrun in master mode", underrun, 0);
  endtask

  task automatic t_fifo();
    int b0;
    dbuf_en = 1'b1; fifo_en = 1'b1; clk_master = 1'b1;
    b0 = rx_n;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_data = 8'(8'h10 + i);
    end
    @(negedge clk); wr_en = 1'b0;
    chk("R8 overflow on full FIFO", overflow, 1);
    repeat (160) @(negedge clk);
    chk("R7 hold refilled from FIFO", hold_empty, 0);
    repeat (4 * FRAME + 60) @(negedge clk);
    chk("R8 six bytes accepted", rx_n - b0, 6);
    for (int i = 0; i < 6; i++)
      chk("R7 FIFO byte order", rxq[(b0 + i) % 64], 8'h10 + i);
    chk("R8 overflow sticky", overflow, 1);
    rd_status();
    chk("R8 overflow cleared by read", overflow, 0);
  endtask

  task automatic t_slave_ur();
    logic [7:0] b;
    dbuf_en = 1'b1; fifo_en = 1'b0; clk_master = 1'b0;
    wr(8'h5A);
    repeat (3) @(negedge clk);
    sframe(b);
    chk("R6 slave byte", b, 8'h5A);
    chk("R9 no underrun yet", underrun, 0);
    sframe(b);
    chk("R9 idle data during underrun", b, 8'hFF);
    chk("R9 underrun set", underrun, 1);
    rd_status();
    chk("R9 underrun cleared by read", underrun, 0);
  endtask

  task automatic t_slave_b2b();
    logic [7:0] b;
    dbuf_en = 1'b1; fifo_en = 1'b0; clk_master = 1'b0;
    wr(8'h11);
    wr(8'h22);
    repeat (3) @(negedge clk);
    sframe(b);
    chk("R10 first slave byte", b, 8'h11);
    sframe(b);
    chk("R10 refilled slave byte", b, 8'h22);
    chk("R10 no underrun", underrun, 0);
  endtask

  task automatic t_slave_fifo();
    logic [7:0] b;
    dbuf_en = 1'b1; fifo_en = 1'b1; clk_master = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = 8'hA1;
    @(negedge clk); wr_data = 8'hB2;
    @(negedge clk); wr_data = 8'hC3;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    sframe(b);
    chk("R7 slave FIFO byte 0", b, 8'hA1);
    chk("R7 two-stage refill keeps hold full", hold_empty, 0);
    sframe(b);
    chk("R7 slave FIFO byte 1", b, 8'hB2);
    sframe(b);
    chk("R7 slave FIFO byte 2", b, 8'hC3);
    chk("R7 no underrun with FIFO", underrun, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_double();
    t_fifo();
    t_slave_ur();
    t_slave_b2b();
    t_slave_fifo();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule